// File: doc/BRIEF.md
# Device Interrupt Redirection Router

The router takes sixteen edge-triggered device request lines and hands each event to one of eight processor cores, with an 8-bit vector. Every line owns a redirection entry. The entry holds an enable, a delivery mode, a core identifier for single-target delivery, and an 8-bit group mask. In single-target mode, every event from the line goes to the named core. In group mode, events are spread over the set bits of the mask in rotating order.

Software writes the entries through a small register port. The same port also reads back one event counter per core. The router serves one interrupt at a time. It raises a request strobe towards the chosen core, drives the vector, and holds both until that core acknowledges.

A two-state machine does the sequencing. In `ST_IDLE` it looks for an eligible pending line. When it finds one, it takes the transition *pick* to `ST_WAIT_ACK` and latches the line, the core and the mode. When the chosen core acknowledges, it takes the transition *retire* back to `ST_IDLE`. On *retire* it clears the line's pending bit, advances the line's rotation pointer in group mode, and counts the event for that core.

Top module: `irq_route_hub`

## Requirements
- R1: After reset, no core request is asserted, all entries read as zero, all counters read as zero, and every rotation pointer is 0.
- R2: A write to address 0..15 sets that line's entry. The fields are mask in bits [7:0], core id in bits [10:8], group mode in bit 16 (1 = group, 0 = single-target) and enable in bit 24. Reading the address returns these fields, and all other bits read as zero.
- R3: A rising edge on a line whose enable is 1 makes it pending. A rising edge on a line whose enable is 0 is ignored, and it is not delivered even after the line is enabled later.
- R4: A single-target line is delivered to the core named by its core id field.
- R5: A group-mode line is delivered to the first set mask bit found from its pointer upward, wrapping at 8. The pointer then becomes that core plus 1, modulo 8. Writing the entry resets the pointer to 0.
- R6: A group-mode line with an all-zero mask stays pending and is never served. Other lines are still served. Once a nonzero mask is written, the line is delivered.
- R7: When several eligible lines are pending, the lowest-numbered one is served first.
- R8: At most one core request is asserted at a time. While it is asserted, the vector equals the line number plus 32.
- R9: The request and vector stay stable until the chosen core acknowledges. Acknowledges from other cores are ignored. The cycle after the accepted acknowledge, the request is low and the line is no longer pending.
- R10: Each core has a 16-bit counter of accepted deliveries, read at address 32 plus the core number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 16 | Device request lines, edge-sensitive |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| core_irq_req | output | 8 | Per-core interrupt request |
| irq_vector | output | 8 | Vector of the current delivery |
| core_ack | input | 8 | Per-core acknowledge |

## Verification
The assertions rely on one-hot request generation and a stable delivery. They assume that any acknowledge pulse lasts one cycle and is raised only while that core's request is high. The bench drives every acknowledge that way: it raises the acknowledge for exactly one cycle after it sees the request. The one exception is a deliberate one-cycle acknowledge on a core that was not chosen. Device lines are pulsed for a single cycle, and entry writes happen only while the router is idle or holds a blocked line, so a latched delivery is never rewritten mid-flight.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int NUM_CORES = 8;
    localparam int CORE_ID_W = $clog2(NUM_CORES);
    localparam int VEC_W     = 8;

    typedef enum logic [0:0] {
        ST_IDLE     = 1'b0,
        ST_WAIT_ACK = 1'b1
    } route_state_t;

    typedef struct packed {
        logic                 en;
        logic                 grp_mode;
        logic [CORE_ID_W-1:0] core_id;
        logic [NUM_CORES-1:0] mask;
    } route_entry_t;
endpackage

// File: rtl/irq_edge_pending.sv
module irq_edge_pending #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] enable,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pending
);
    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;

    assign rise    = irq_in & ~prev_q & enable;
    assign pending = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= irq_in;
            // a fresh edge wins over a same-cycle clear
            pend_q <= (pend_q & ~clr) | rise;
        end
    end
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick import irq_route_pkg::*; (
    input  logic [NUM_CORES-1:0] mask,
    input  logic [CORE_ID_W-1:0] ptr,
    output logic [CORE_ID_W-1:0] target,
    output logic                 hit
);
    logic [CORE_ID_W-1:0] probe;

    always_comb begin
        hit    = 1'b0;
        target = ptr;
        probe  = ptr;
        // descending scan so the smallest offset from ptr wins
        for (int k = NUM_CORES - 1; k >= 0; k--) begin
            probe = ptr + CORE_ID_W'(k);
            if (mask[probe]) begin
                hit    = 1'b1;
                target = probe;
            end
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub import irq_route_pkg::*; #(
    parameter int NUM_LINES = 16,
    parameter int CNT_W     = 16,
    parameter int VEC_BASE  = 32,
    parameter int ADDR_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_CORES-1:0] core_irq_req,
    output logic [VEC_W-1:0]     irq_vector,
    input  logic [NUM_CORES-1:0] core_ack
);
    localparam int LINE_W   = $clog2(NUM_LINES);
    localparam int CNT_BASE = 2 * NUM_LINES;

    route_entry_t          entry_q [NUM_LINES];
    logic [CORE_ID_W-1:0]  ptr_q   [NUM_LINES];
    logic [CNT_W-1:0]      cnt_q   [NUM_CORES];
    logic [CORE_ID_W-1:0]  cand_core [NUM_LINES];
    logic [CORE_ID_W-1:0]  rr_target [NUM_LINES];
    logic [NUM_LINES-1:0]  rr_hit;
    logic [NUM_LINES-1:0]  en_vec;
    logic [NUM_LINES-1:0]  pending;
    logic [NUM_LINES-1:0]  eligible;
    logic [NUM_LINES-1:0]  clr_vec;
    logic                  any_elig;
    logic [LINE_W-1:0]     pick_idx;

    route_state_t          state_q, state_d;
    logic [LINE_W-1:0]     sel_line_q;
    logic [CORE_ID_W-1:0]  sel_core_q;
    logic                  sel_grp_q;
    logic                  ack_hit;
    logic                  do_pick;
    logic                  do_retire;
    logic                  entry_wr;
    logic [LINE_W-1:0]     wr_line;
    logic [31:0]           unused_wdata;

    assign entry_wr     = reg_wr_en && (reg_addr < ADDR_W'(NUM_LINES));
    assign wr_line      = reg_addr[LINE_W-1:0];
    assign unused_wdata = {reg_wdata[31:25], reg_wdata[23:17], reg_wdata[15:11], 13'b0};

    // ---------------- per-line structure ----------------
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            irq_rr_pick u_rr (
                .mask   (entry_q[g].mask),
                .ptr    (ptr_q[g]),
                .target (rr_target[g]),
                .hit    (rr_hit[g])
            );
            assign en_vec[g]    = entry_q[g].en;
            assign cand_core[g] = entry_q[g].grp_mode ? rr_target[g] : entry_q[g].core_id;
            assign eligible[g]  = pending[g] & (~entry_q[g].grp_mode | rr_hit[g]);
            assign clr_vec[g]   = do_retire && (sel_line_q == LINE_W'(g));
        end
    endgenerate

    irq_edge_pending #(.N(NUM_LINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .enable  (en_vec),
        .clr     (clr_vec),
        .pending (pending)
    );

    irq_prio_enc #(.N(NUM_LINES)) u_prio (
        .req (eligible),
        .any (any_elig),
        .idx (pick_idx)
    );

    // ---------------- state machine ----------------
    assign ack_hit = core_ack[sel_core_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        do_pick   = 1'b0;
        do_retire = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_elig) begin
                    do_pick = 1'b1;
                    state_d = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (ack_hit) begin
                    do_retire = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        core_irq_req = '0;
        irq_vector   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT_ACK: begin
                core_irq_req[sel_core_q] = 1'b1;
                irq_vector = VEC_W'(sel_line_q) + VEC_W'(VEC_BASE);
            end
            default: ;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_line_q <= '0;
            sel_core_q <= '0;
            sel_grp_q  <= 1'b0;
        end else if (do_pick) begin
            sel_line_q <= pick_idx;
            sel_core_q <= cand_core[pick_idx];
            sel_grp_q  <= entry_q[pick_idx].grp_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                entry_q[i] <= '0;
                ptr_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (entry_wr && wr_line == LINE_W'(i)) begin
                    entry_q[i].mask     <= reg_wdata[7:0];
                    entry_q[i].core_id  <= reg_wdata[10:8];
                    entry_q[i].grp_mode <= reg_wdata[16];
                    entry_q[i].en       <= reg_wdata[24];
                    ptr_q[i]            <= '0;
                end else if (do_retire && sel_grp_q && sel_line_q == LINE_W'(i)) begin
                    ptr_q[i] <= sel_core_q + CORE_ID_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CORES; c++) cnt_q[c] <= '0;
        end else if (do_retire) begin
            cnt_q[sel_core_q] <= cnt_q[sel_core_q] + CNT_W'(1);
        end
    end

    // ---------------- register read ----------------
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                reg_rdata[7:0]  = entry_q[i].mask;
                reg_rdata[10:8] = entry_q[i].core_id;
                reg_rdata[16]   = entry_q[i].grp_mode;
                reg_rdata[24]   = entry_q[i].en;
            end
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            if (reg_addr == ADDR_W'(CNT_BASE + c)) reg_rdata[CNT_W-1:0] = cnt_q[c];
        end
    end
endmodule

// File: rtl/irq_route_hub_chk.sv
module irq_route_hub_chk import irq_route_pkg::*; #(
    parameter int NUM_LINES = 16,
    parameter int VEC_BASE  = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] core_irq_req,
    input logic [NUM_CORES-1:0] core_ack,
    input logic [VEC_W-1:0]     irq_vector
);
    p_req_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_irq_req));

    p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_irq_req) |-> (int'(irq_vector) >= VEC_BASE && int'(irq_vector) < VEC_BASE + NUM_LINES));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(core_irq_req & ~core_ack)) |=> ($stable(core_irq_req) && $stable(irq_vector)));

    p_drop_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(core_irq_req & core_ack)) |=> (core_irq_req == '0));
endmodule

bind irq_route_hub irq_route_hub_chk #(.NUM_LINES(NUM_LINES), .VEC_BASE(VEC_BASE)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_irq_req (core_irq_req),
    .core_ack     (core_ack),
    .irq_vector   (irq_vector)
);

// File: tb/irq_route_hub_tb_top.sv
module irq_route_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  core_irq_req;
    logic [7:0]  irq_vector;
    logic [7:0]  core_ack = '0;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt [8];

    always #2 clk = ~clk;

    irq_route_hub dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_irq_req(core_irq_req), .irq_vector(irq_vector), .core_ack(core_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] entry_word(input bit en, input bit grp, input int core, input logic [7:0] mask);
        return {7'b0, en, 7'b0, grp, 5'b0, 3'(core), mask};
    endfunction

    task automatic wr_entry(input int line, input bit en, input bit grp, input int core, input logic [7:0] mask);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = 6'(line);
        reg_wdata = entry_word(en, grp, core, mask) | 32'hFE00_F800;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_addr  = 6'(line);
        #0.5;
        chk(reg_rdata == entry_word(en, grp, core, mask), "R2 entry readback", reg_rdata, entry_word(en, grp, core, mask));
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk);
        irq_in = m;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic expect_idle(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) @(negedge clk);
        chk(core_irq_req == '0, tag, core_irq_req, 0);
    endtask

    task automatic expect_delivery(input int core, input int vec, input string tag, input bit stray_ack);
        int waited = 0;
        @(negedge clk);
        while (core_irq_req == '0 && waited < 30) begin
            @(negedge clk);
            waited++;
        end
        chk(core_irq_req == 8'(1 << core), tag, core_irq_req, 32'(1 << core));
        chk(irq_vector == 8'(vec), "R8 vector", irq_vector, vec);
        if (stray_ack) begin
            core_ack = 8'(1 << ((core + 1) % 8));
            @(negedge clk);
            core_ack = '0;
            chk(core_irq_req == 8'(1 << core), "R9 stray ack ignored", core_irq_req, 32'(1 << core));
        end
        core_ack = 8'(1 << core);
        @(negedge clk);
        core_ack = '0;
        chk(core_irq_req == '0, "R9 request drops after ack", core_irq_req, 0);
        exp_cnt[core]++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) exp_cnt[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(core_irq_req == '0, "R1 no request after reset", core_irq_req, 0);
        for (int a = 0; a < 40; a++) begin
            reg_addr = 6'(a);
            #0.5;
            chk(reg_rdata == '0, "R1 register zero after reset", reg_rdata, 0);
        end

        // R4/R8: single-target sweep over every line
        for (int ln = 0; ln < 16; ln++) begin
            wr_entry(ln, 1'b1, 1'b0, (ln * 3) % 8, 8'hFF);
            pulse(16'(1 << ln));
            expect_delivery((ln * 3) % 8, ln + 32, "R4 single-target core", ln == 0);
        end

        // R5: group rotation, mask bits 1,2,5,7 -> 1,2,5,7,1,2
        wr_entry(3, 1'b1, 1'b1, 0, 8'hA6);
        for (int n = 0; n < 6; n++) begin
            int seq [4] = '{1, 2, 5, 7};
            pulse(16'h0008);
            expect_delivery(seq[n % 4], 35, "R5 round-robin order", 1'b0);
        end
        // R5: rewrite resets pointer; mask 0x81 -> 0,7,0,7
        wr_entry(12, 1'b1, 1'b1, 5, 8'h81);
        for (int n = 0; n < 4; n++) begin
            pulse(16'h1000);
            expect_delivery((n % 2) * 7, 44, "R5 round-robin wrap", 1'b0);
        end
        wr_entry(3, 1'b1, 1'b1, 0, 8'hA6);
        pulse(16'h0008);
        expect_delivery(1, 35, "R5 pointer reset on write", 1'b0);

        // R7: lines 2 and 5 together, lowest first
        pulse(16'h0024);
        expect_delivery(6, 34, "R7 lowest line first", 1'b0);
        expect_delivery(7, 37, "R7 second line after", 1'b0);

        // R3: disabled line ignored, stays ignored after enabling
        wr_entry(6, 1'b0, 1'b0, 2, 8'h00);
        pulse(16'h0040);
        expect_idle(6, "R3 disabled edge ignored");
        wr_entry(6, 1'b1, 1'b0, 2, 8'h00);
        expect_idle(6, "R3 no late delivery after enable");
        pulse(16'h0040);
        expect_delivery(2, 38, "R3 enabled edge delivered", 1'b0);

        // R6: zero group mask blocks line 4, line 9 still served
        wr_entry(4, 1'b1, 1'b1, 0, 8'h00);
        wr_entry(9, 1'b1, 1'b0, 3, 8'h00);
        pulse(16'h0210);
        expect_delivery(3, 41, "R6 other line served", 1'b0);
        expect_idle(6, "R6 zero mask blocks");
        wr_entry(4, 1'b1, 1'b1, 0, 8'h10);
        expect_delivery(4, 36, "R6 delivered after mask set", 1'b0);

        // R10: per-core counters
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            reg_addr = 6'(32 + c);
            #0.5;
            chk(reg_rdata == 32'(exp_cnt[c]), "R10 core counter", reg_rdata, exp_cnt[c]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule